// File: doc/BRIEF.md
# I2C Engine Access Arbiter

This block decides who drives a single shared I2C master engine: a software requester that issues register-style commands (GO, done-using, status clear), or an internal hardware requester that holds a request line for as long as it needs the engine. It keeps one ownership register, reports it as a 2-bit status, and raises a grant toward whichever side owns the engine. The bus signalling and the byte buffer live elsewhere. The arbiter only sees a pulse that marks the end of a software transfer.

A single configuration bit sets the software priority. At normal software priority the hardware requester ranks higher, so it may take the engine from software at any moment. If a software transfer was in flight when that happened, the arbiter hands the engine back when hardware lets go and pulses a restart request to the sequencer. At high software priority, hardware waits until software gives the engine up. A second configuration bit sets the policy for a software GO that arrives while hardware owns the engine: the GO either waits and runs when hardware leaves, or it is dropped.

Top module: `i2c_access_arbiter`

## Requirements
- R1: `own_status` uses 0 for idle, 1 for software owner and 2 for hardware owner, and never shows 3. After reset it reads 0. `sw_grant` is high exactly when the status is 1, and `hw_grant` is high exactly when the status is 2.
- R2: A `sw_go` pulse sampled while the status is idle, with `hw_req` low, moves the status to 1 on that clock edge.
- R3: If `hw_req` and `sw_go` are sampled together while idle, hardware takes the engine when `cfg_sw_high`=0 (normal) and software takes it when `cfg_sw_high`=1 (high).
- R4: With `cfg_sw_high`=0, `hw_req` sampled while software owns the engine moves the status to 2 on that edge.
- R5: With `cfg_sw_high`=1, software keeps the engine while `hw_req` is high until it releases the engine. Hardware gets the engine on the edge after the release.
- R6: If hardware took the engine while a software transfer was in flight, then when `hw_req` is sampled low the status returns to 1 and `sw_restart` is high for exactly that one cycle.
- R7: With `cfg_drop_go`=0, a `sw_go` sampled while hardware owns the engine is held. When `hw_req` is sampled low the status moves to 1.
- R8: With `cfg_drop_go`=1, a `sw_go` sampled while hardware owns the engine is discarded. When `hw_req` is sampled low the status moves to 0.
- R9: A `sw_release` pulse ends the software claim. The status goes to 0 on that edge if software owned the engine. If hardware owned it, the status stays 2, and when hardware leaves there is no restart and no held GO runs.
- R10: An `own_clr` pulse clears the software claim in the same way as `sw_release`.
- R11: A `sw_xfer_done` pulse while software owns the engine marks the transfer finished. A later preemption then causes no restart, and the status goes to 0 when hardware leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sw_high | input | 1 | Software priority: 0 normal, 1 high |
| cfg_drop_go | input | 1 | 1: drop a software GO issued while hardware owns the engine |
| sw_go | input | 1 | Software GO pulse |
| sw_release | input | 1 | Software done-using pulse |
| own_clr | input | 1 | Status-reset pulse that clears the software claim |
| sw_xfer_done | input | 1 | Engine reports the software transfer finished |
| hw_req | input | 1 | Hardware requester wants the engine (level) |
| sw_grant | output | 1 | Engine granted to software |
| hw_grant | output | 1 | Engine granted to hardware |
| own_status | output | 2 | Ownership code |
| sw_restart | output | 1 | One-cycle request to restart a preempted software transfer |

## Verification
The bench uses several patterns to tell the arbiter's decisions apart. Lone software and lone hardware requests confirm the basic grants. Simultaneous requests at each priority setting show the tie-break. A preemption while a software transfer is in flight is compared with one taken after the transfer has finished, which shows whether a restart is owed. A GO issued during hardware ownership is run under both queue policies, which tells queuing from dropping by the status after hardware leaves. Releases and status clears are applied both while software owns the engine and while hardware does, which shows that a claim given up leaves nothing behind.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  localparam int OWN_W = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_IDLE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_HW   = 2'd2
  } own_e;

  // hardware may pull the engine away from software only at normal sw priority
  function automatic logic hw_may_preempt(input logic sw_high);
    return !sw_high;
  endfunction

  // idle tie-break: hardware takes the engine unless software has high priority
  function automatic logic hw_takes_idle(input logic hw_req, input logic sw_go,
                                         input logic sw_high);
    return hw_req && (!sw_go || !sw_high);
  endfunction

  // a GO seen during hardware ownership is kept for later when queuing is allowed
  function automatic logic go_is_held(input logic sw_go, input logic drop_go);
    return sw_go && !drop_go;
  endfunction

endpackage

// File: rtl/i2c_arb_next.sv
module i2c_arb_next
  import i2c_arb_pkg::*;
(
  input  own_e owner,
  input  logic sw_busy,
  input  logic sw_preempted,
  input  logic sw_pend,
  input  logic cfg_sw_high,
  input  logic cfg_drop_go,
  input  logic sw_go,
  input  logic sw_release,
  input  logic own_clr,
  input  logic sw_xfer_done,
  input  logic hw_req,
  output own_e owner_nxt,
  output logic ev_launch,
  output logic ev_finish,
  output logic ev_preempt,
  output logic ev_queue,
  output logic ev_restart,
  output logic ev_clear
);

  logic drop_claim;
  assign drop_claim = sw_release | own_clr;

  always_comb begin
    owner_nxt  = owner;
    ev_launch  = 1'b0;
    ev_finish  = 1'b0;
    ev_preempt = 1'b0;
    ev_queue   = 1'b0;
    ev_restart = 1'b0;
    ev_clear   = 1'b0;
    case (owner)
      OWN_IDLE: begin
        if (hw_takes_idle(hw_req, sw_go, cfg_sw_high)) begin
          owner_nxt = OWN_HW;
          ev_queue  = go_is_held(sw_go, cfg_drop_go);
        end else if (sw_go) begin
          owner_nxt = OWN_SW;
          ev_launch = 1'b1;
        end
      end
      OWN_SW: begin
        if (drop_claim) begin
          owner_nxt = OWN_IDLE;
          ev_clear  = 1'b1;
        end else if (hw_req && hw_may_preempt(cfg_sw_high)) begin
          owner_nxt  = OWN_HW;
          ev_preempt = sw_busy | sw_go;
        end else if (sw_go) begin
          ev_launch = 1'b1;
        end else if (sw_xfer_done) begin
          ev_finish = 1'b1;
        end
      end
      OWN_HW: begin
        ev_clear = drop_claim;
        if (hw_req) begin
          ev_queue = !drop_claim && go_is_held(sw_go, cfg_drop_go);
        end else if (!drop_claim && sw_preempted) begin
          owner_nxt  = OWN_SW;
          ev_restart = 1'b1;
        end else if (!drop_claim && (sw_pend || go_is_held(sw_go, cfg_drop_go))) begin
          owner_nxt = OWN_SW;
          ev_launch = 1'b1;
        end else begin
          owner_nxt = OWN_IDLE;
        end
      end
      default: owner_nxt = OWN_IDLE;
    endcase
  end

endmodule

// File: rtl/i2c_arb_flags.sv
module i2c_arb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_launch,
  input  logic ev_finish,
  input  logic ev_preempt,
  input  logic ev_queue,
  input  logic ev_restart,
  input  logic ev_clear,
  output logic sw_busy,
  output logic sw_preempted,
  output logic sw_pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_busy      <= 1'b0;
      sw_preempted <= 1'b0;
      sw_pend      <= 1'b0;
    end else if (ev_clear) begin
      sw_busy      <= 1'b0;
      sw_preempted <= 1'b0;
      sw_pend      <= 1'b0;
    end else begin
      if (ev_launch || ev_preempt) sw_busy <= 1'b1;
      else if (ev_finish)          sw_busy <= 1'b0;

      if (ev_preempt)      sw_preempted <= 1'b1;
      else if (ev_restart) sw_preempted <= 1'b0;

      // a held GO behind a preempted transfer folds into the restart
      if (ev_queue)                      sw_pend <= 1'b1;
      else if (ev_restart || ev_launch)  sw_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_access_arbiter.sv
module i2c_access_arbiter
  import i2c_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sw_high,
  input  logic             cfg_drop_go,
  input  logic             sw_go,
  input  logic             sw_release,
  input  logic             own_clr,
  input  logic             sw_xfer_done,
  input  logic             hw_req,
  output logic             sw_grant,
  output logic             hw_grant,
  output logic [OWN_W-1:0] own_status,
  output logic             sw_restart
);

  own_e owner, owner_nxt;
  logic sw_busy, sw_preempted, sw_pend;
  logic ev_launch, ev_finish, ev_preempt, ev_queue, ev_restart, ev_clear;

  i2c_arb_next u_next (
    .owner        (owner),
    .sw_busy      (sw_busy),
    .sw_preempted (sw_preempted),
    .sw_pend      (sw_pend),
    .cfg_sw_high  (cfg_sw_high),
    .cfg_drop_go  (cfg_drop_go),
    .sw_go        (sw_go),
    .sw_release   (sw_release),
    .own_clr      (own_clr),
    .sw_xfer_done (sw_xfer_done),
    .hw_req       (hw_req),
    .owner_nxt    (owner_nxt),
    .ev_launch    (ev_launch),
    .ev_finish    (ev_finish),
    .ev_preempt   (ev_preempt),
    .ev_queue     (ev_queue),
    .ev_restart   (ev_restart),
    .ev_clear     (ev_clear)
  );

  i2c_arb_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_launch    (ev_launch),
    .ev_finish    (ev_finish),
    .ev_preempt   (ev_preempt),
    .ev_queue     (ev_queue),
    .ev_restart   (ev_restart),
    .ev_clear     (ev_clear),
    .sw_busy      (sw_busy),
    .sw_preempted (sw_preempted),
    .sw_pend      (sw_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner      <= OWN_IDLE;
      sw_restart <= 1'b0;
    end else begin
      owner      <= owner_nxt;
      sw_restart <= ev_restart;
    end
  end

  assign own_status = owner;
  assign sw_grant   = (owner == OWN_SW);
  assign hw_grant   = (owner == OWN_HW);

endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_sw_high,
  input logic       sw_go,
  input logic       sw_release,
  input logic       own_clr,
  input logic       hw_req,
  input logic       sw_grant,
  input logic       hw_grant,
  input logic [1:0] own_status,
  input logic       sw_restart,
  input logic       ev_preempt
);

  assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    own_status != 2'd3);

  assert_idle_go_grants_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (own_status == 2'd0 && sw_go && !hw_req) |=> sw_grant);

  assert_preempt_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_preempt |=> hw_grant);

  assert_high_prio_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_grant && cfg_sw_high && !sw_release && !own_clr) |=> sw_grant);

  assert_restart_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_restart |=> !sw_restart);

  assert_restart_after_hw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_restart |-> (sw_grant && $past(hw_grant)));

  assert_release_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_grant && sw_release) |=> !sw_grant);

  assert_clear_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    own_clr |=> !sw_grant);

  assert_hw_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_grant && hw_req) |=> hw_grant);

endmodule

bind i2c_access_arbiter i2c_arb_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_sw_high (cfg_sw_high),
  .sw_go       (sw_go),
  .sw_release  (sw_release),
  .own_clr     (own_clr),
  .hw_req      (hw_req),
  .sw_grant    (sw_grant),
  .hw_grant    (hw_grant),
  .own_status  (own_status),
  .sw_restart  (sw_restart),
  .ev_preempt  (ev_preempt)
);

// File: tb/i2c_access_arbiter_tb_top.sv
module i2c_access_arbiter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sw_high = 1'b0, cfg_drop_go = 1'b0;
  logic sw_go = 1'b0, sw_release = 1'b0, own_clr = 1'b0;
  logic sw_xfer_done = 1'b0, hw_req = 1'b0;
  logic sw_grant, hw_grant, sw_restart;
  logic [1:0] own_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] q_st[$];
  bit         q_rs[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  i2c_access_arbiter dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sw_high  (cfg_sw_high),
    .cfg_drop_go  (cfg_drop_go),
    .sw_go        (sw_go),
    .sw_release   (sw_release),
    .own_clr      (own_clr),
    .sw_xfer_done (sw_xfer_done),
    .hw_req       (hw_req),
    .sw_grant     (sw_grant),
    .hw_grant     (hw_grant),
    .own_status   (own_status),
    .sw_restart   (sw_restart)
  );

  task automatic compare(input logic [1:0] st, input bit rs, input string tag);
    checks++;
    if (own_status !== st || sw_grant !== (st == 2'd1) ||
        hw_grant !== (st == 2'd2) || sw_restart !== rs) begin
      errors++;
      $display("FAIL %s: status=%0d sw_grant=%0b hw_grant=%0b restart=%0b expected status=%0d restart=%0b",
               tag, own_status, sw_grant, hw_grant, sw_restart, st, rs);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed for the monitor
  task automatic step(input bit hr, input bit go, input bit rel, input bit clr,
                      input bit xd, input logic [1:0] st, input bit rs,
                      input string tag);
    @(negedge clk);
    hw_req = hr; sw_go = go; sw_release = rel; own_clr = clr; sw_xfer_done = xd;
    q_st.push_back(st);
    q_rs.push_back(rs);
    q_tag.push_back(tag);
  endtask

  // monitor: compares just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_st.size() > 0) compare(q_st.pop_front(), q_rs.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(2'd0, 1'b0, "R1 reset idle");
    rst_n = 1'b1;

    // R2 software alone
    step(0,1,0,0,0, 2'd1, 0, "R2 idle go grants sw");
    step(0,0,0,0,0, 2'd1, 0, "R2 sw holds");
    // R4 / R6 preempt in-flight transfer, then restart
    step(1,0,0,0,0, 2'd2, 0, "R4 hw preempts");
    step(1,0,0,0,0, 2'd2, 0, "R4 hw holds");
    step(0,0,0,0,0, 2'd1, 1, "R6 restart pulse");
    step(0,0,0,0,0, 2'd1, 0, "R6 restart one cycle");
    // R11 finished transfer, no restart
    step(0,0,0,0,1, 2'd1, 0, "R11 transfer done");
    step(1,0,0,0,0, 2'd2, 0, "R11 hw takes");
    step(0,0,0,0,0, 2'd0, 0, "R11 no restart");
    // R9 release while sw owns
    step(0,1,0,0,0, 2'd1, 0, "R9 go");
    step(0,0,1,0,0, 2'd0, 0, "R9 release to idle");
    step(0,0,0,0,0, 2'd0, 0, "R9 stays idle");
    // R9 release while hw owns a preempted claim
    step(0,1,0,0,0, 2'd1, 0, "R9 go again");
    step(1,0,0,0,0, 2'd2, 0, "R9 hw preempts");
    step(1,0,1,0,0, 2'd2, 0, "R9 release during hw");
    step(0,0,0,0,0, 2'd0, 0, "R9 no restart after release");
    // R10 status clear
    step(0,1,0,0,0, 2'd1, 0, "R10 go");
    step(0,0,0,1,0, 2'd0, 0, "R10 clear to idle");
    // R7 queued go
    step(1,0,0,0,0, 2'd2, 0, "R7 hw owns");
    step(1,1,0,0,0, 2'd2, 0, "R7 go held");
    step(1,0,0,0,0, 2'd2, 0, "R7 hw still owns");
    step(0,0,0,0,0, 2'd1, 0, "R7 held go runs");
    step(0,0,1,0,0, 2'd0, 0, "R7 release");
    // R8 dropped go
    cfg_drop_go = 1'b1;
    step(1,0,0,0,0, 2'd2, 0, "R8 hw owns");
    step(1,1,0,0,0, 2'd2, 0, "R8 go dropped");
    step(0,0,0,0,0, 2'd0, 0, "R8 idle after hw");
    cfg_drop_go = 1'b0;
    // R3 tie at normal priority
    step(1,1,0,0,0, 2'd2, 0, "R3 tie normal hw wins");
    step(0,0,0,0,0, 2'd1, 0, "R3 losing go held then runs");
    step(0,0,1,0,0, 2'd0, 0, "R3 release");
    // R3 tie at high priority, R5 no preemption
    @(negedge clk); cfg_sw_high = 1'b1;
    step(1,1,0,0,0, 2'd1, 0, "R3 tie high sw wins");
    step(1,0,0,0,0, 2'd1, 0, "R5 sw keeps");
    step(1,0,0,0,0, 2'd1, 0, "R5 sw still keeps");
    step(1,0,1,0,0, 2'd0, 0, "R5 release");
    step(1,0,0,0,0, 2'd2, 0, "R5 hw after release");
    step(0,0,0,0,0, 2'd0, 0, "R5 hw leaves");
    step(0,0,0,0,0, 2'd0, 0, "R1 idle");

    while (q_st.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule